// File: doc/BRIEF.md
# Programmable-Threshold Soft Decision Slicer

This block converts one signed in-phase sample and one signed quadrature sample into a 3-bit soft decision for each rail. For each rail it takes the sample's magnitude and compares it against T, 2T and 3T, where T is an unsigned threshold set at run time. That comparison places the sample in one of four confidence regions. The region and the sample's sign together form the 3-bit code.

A single format input selects, sample by sample, one of two output codings: sign/magnitude or two's complement. Both codings give the same code for positive samples and differ only for negative ones. The decisions are registered, so they appear one clock after a valid input. They hold their value while no valid input arrives.

Top module: `soft_slicer`

## Requirements
- R1: The magnitude |x| selects a region using strict comparisons: region 3 if |x| > 3T, otherwise region 2 if |x| > 2T, otherwise region 1 if |x| > T, otherwise region 0. A magnitude equal to a boundary falls in the lower region.
- R2: When `fmt_twos` is 0 (sign/magnitude), a non-negative sample in region r produces {0,r}, and a negative sample in region r produces {1,r}. For example, a negative sample with 2T < |x| <= 3T gives 110.
- R3: When `fmt_twos` is 1 (two's complement), a non-negative sample in region r produces {0,r}, and a negative sample in region r produces {1,~r}. So 111 is the weakest negative code and 100 the strongest.
- R4: Bit 2 of each code is the MSB of its input sample. A sample of exactly zero gives 000 in both formats.
- R5: No intermediate value overflows. The most negative sample has magnitude 2^(W-1), and the threshold may take any value up to its full range, including zero; both extremes classify exactly.
- R6: `out_vld` equals `in_vld` delayed by one clock. The codes for a valid sample appear on the next clock.
- R7: While `in_vld` is low, `i_soft` and `q_soft` keep their previous value, whatever the sample, threshold and format inputs do.
- R8: The two rails are classified independently, using the same threshold and the same format.
- R9: The threshold and format applied to a sample are the values present in the same cycle as that sample. A change takes effect on the very sample that arrives with it.
- R10: While `rst_n` is low, `out_vld`, `i_soft` and `q_soft` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_vld | input | 1 | Samples are valid this cycle |
| i_smp | input | W | In-phase sample, two's complement |
| q_smp | input | W | Quadrature sample, two's complement |
| thr | input | TW | Threshold T, unsigned |
| fmt_twos | input | 1 | 1 selects two's complement codes, 0 selects sign/magnitude |
| out_vld | output | 1 | Codes below are new this cycle |
| i_soft | output | 3 | In-phase soft decision |
| q_soft | output | 3 | Quadrature soft decision |

## Verification
Two things can coincide in one cycle: a change of threshold or format, and a valid sample that must be classified with the new setting. The bench provokes this by moving `thr` or `fmt_twos` on the same cycle as a sample that sits just above or just below a boundary. It also switches both on a cycle where `in_vld` is low, to check that the held codes do not move. A behavioural reference model computes the expected codes from integers on every clock, and the bench compares them with the registered outputs.

// File: rtl/soft_slicer.sv
module soft_slicer #(
  parameter int W  = 8,
  parameter int TW = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [W-1:0]  i_smp,
  input  logic [W-1:0]  q_smp,
  input  logic [TW-1:0] thr,
  input  logic          fmt_twos,
  output logic          out_vld,
  output logic [2:0]    i_soft,
  output logic [2:0]    q_soft
);

  localparam int CW = (W > TW + 2) ? W : TW + 2;

  logic [CW-1:0] t1, t2, t3;
  logic [2:0]    i_code, q_code;

  assign t1 = CW'(thr);
  assign t2 = CW'({thr, 1'b0});
  assign t3 = t2 + t1;

  function automatic logic [2:0] classify(input logic [W-1:0] x,
                                          input logic [CW-1:0] a,
                                          input logic [CW-1:0] b,
                                          input logic [CW-1:0] c,
                                          input logic tc);
    logic          neg;
    logic [W-1:0]  ax;
    logic [CW-1:0] m;
    logic [1:0]    r;
    neg = x[W-1];
    ax  = neg ? (~x + 1'b1) : x;
    m   = CW'(ax);
    if (m > c)      r = 2'd3;
    else if (m > b) r = 2'd2;
    else if (m > a) r = 2'd1;
    else            r = 2'd0;
    if (!neg)    return {1'b0, r};
    else if (tc) return {1'b1, ~r};
    else         return {1'b1, r};
  endfunction

  assign i_code = classify(i_smp, t1, t2, t3, fmt_twos);
  assign q_code = classify(q_smp, t1, t2, t3, fmt_twos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      i_soft  <= 3'b000;
      q_soft  <= 3'b000;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        i_soft <= i_code;
        q_soft <= q_code;
      end
    end
  end

  assert_vld_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_vld == $past(in_vld)));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_vld)) |-> ($stable(i_soft) && $stable(q_soft)));

  assert_sign_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_vld)) |->
      (i_soft[2] == $past(i_smp[W-1]) && q_soft[2] == $past(q_smp[W-1])));

  assert_zero_weak_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_vld) && $past(i_smp) == '0) |-> (i_soft == 3'b000));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_vld) && $past(thr) == '0 && $past(i_smp) != '0)
      |-> (i_soft[1:0] == ($past(fmt_twos) && i_soft[2] ? 2'b00 : 2'b11)));

endmodule

// File: tb/sim_soft_slicer.sv
`timescale 1ns/100ps
module sim_soft_slicer;
  localparam int W  = 8;
  localparam int TW = W - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [W-1:0]  i_smp = '0, q_smp = '0;
  logic [TW-1:0] thr = '0;
  logic          fmt_twos = 1'b0;
  logic          out_vld;
  logic [2:0]    i_soft, q_soft;

  int checks = 0, errors = 0;
  logic       e_vld = 1'b0;
  logic [2:0] e_i = 3'b000, e_q = 3'b000;

  always #2.5 clk = ~clk;

  soft_slicer #(.W(W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .i_smp(i_smp), .q_smp(q_smp),
    .thr(thr), .fmt_twos(fmt_twos), .out_vld(out_vld), .i_soft(i_soft), .q_soft(q_soft));

  function automatic logic [2:0] model(input int x, input int t, input bit tc);
    int m, r;
    m = (x < 0) ? -x : x;
    if (m > 3*t)      r = 3;
    else if (m > 2*t) r = 2;
    else if (m > t)   r = 1;
    else              r = 0;
    if (x >= 0) return 3'(r);
    return tc ? 3'(7 - r) : 3'(4 + r);
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit v, input int xi, input int xq,
                     input int t, input bit tc);
    in_vld = v; i_smp = W'(xi); q_smp = W'(xq); thr = TW'(t); fmt_twos = tc;
    if (v) begin
      e_i = model(xi, t, tc);
      e_q = model(xq, t, tc);
    end
    e_vld = v;
    @(negedge clk);
    chk(tag, out_vld, e_vld, "out_vld");
    chk(tag, i_soft, e_i, "i_soft");
    chk(tag, q_soft, e_q, "q_soft");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    repeat (3) @(negedge clk);
    in_vld = 1'b1; i_smp = 8'd100; q_smp = 8'd50; thr = 7'd3;
    @(negedge clk);
    chk("R10", out_vld, 0, "out_vld in reset");
    chk("R10", i_soft, 0, "i_soft in reset");
    chk("R10", q_soft, 0, "q_soft in reset");
    in_vld = 1'b0;
    rst_n = 1'b1;
    // R1 R2 boundaries, sign/magnitude, T=20
    cyc("R1", 1, 0, 20, 20, 0);
    cyc("R1", 1, 21, 40, 20, 0);
    cyc("R1", 1, 41, 60, 20, 0);
    cyc("R1", 1, 61, 127, 20, 0);
    cyc("R2", 1, -20, -21, 20, 0);
    cyc("R2", 1, -41, -61, 20, 0);
    cyc("R2", 1, -50, -40, 20, 0);
    chk("R2", i_soft, 3'b110, "neg 2T..3T code");
    // R3 two's complement
    cyc("R3", 1, -20, -21, 20, 1);
    cyc("R3", 1, -41, -61, 20, 1);
    chk("R3", q_soft, 3'b100, "strongest negative");
    cyc("R3", 1, 61, 19, 20, 1);
    // R4 zero in both formats
    cyc("R4", 1, 0, 0, 5, 1);
    cyc("R4", 1, 0, -1, 0, 0);
    // R5 extremes
    cyc("R5", 1, -128, 127, 127, 0);
    cyc("R5", 1, -128, -128, 42, 1);
    cyc("R5", 1, -128, 1, 0, 1);
    cyc("R5", 1, -128, -127, 127, 1);
    // R6 valid gaps
    cyc("R6", 0, 5, 5, 1, 0);
    cyc("R6", 1, 9, -9, 2, 0);
    // R7 hold while idle, with inputs moving
    cyc("R7", 0, -128, 127, 0, 1);
    cyc("R7", 0, 3, -3, 127, 0);
    // R9 setting change on the same cycle as a boundary sample
    cyc("R9", 1, 30, -30, 10, 0);
    cyc("R9", 1, 30, -30, 9, 1);
    cyc("R9", 1, 30, -30, 15, 0);
    // R8 independent rails, pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      int a, b, t;
      bit v, f;
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 8) % 128;
      b = (seed >>> 16) % 128;
      t = (seed >>> 3) & 127;
      if (k % 3 == 0) t = t & 31;
      v = ((seed >>> 24) & 3) != 0;
      f = (seed >>> 27) & 1;
      cyc("R8", v, a, -b, t, f);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule